// File: doc/BRIEF.md
# Upcounting Interval Timer with Buffered Reload

This block is a free-running interval timer. A divide stage cuts the internal clock down by a programmable ratio, and each carry out of that stage advances a 16-bit counter. The counter climbs from zero to a programmable limit. On the next step after the limit it returns to zero and produces an update event. Each update event sets a sticky flag. An interrupt line reflects that flag when its enable bit is set.

The limit has two copies: a value that software writes and an active copy that the compare logic uses. A mode bit selects how they relate. When the mode bit is clear, a written limit is used straight away. When it is set, the written value waits until the next update event. The divide ratio is always held back until an update event.

Software can also force an update event through a self-clearing command bit. All state is reached through a simple single-cycle write strobe and a combinational read port.

Top module: `basic_timer`

## Requirements
- R1: After reset, every readable field is zero and `irq` is low.
- R2: While RUN is 1, the counter advances once every (divide value + 1) internal clocks. With a divide value of 0 it advances on every clock.
- R3: While RUN is 0, the counter and the divide stage hold their values, and no wrap-around event happens.
- R4: When the counter equals the active limit and a step is due, it goes to 0 instead of incrementing. That wrap is an update event and sets the flag.
- R5: With the buffering mode off, a write to LIMIT takes effect at once. For example, a counter at 0x31 under an old limit of 0xFF, given a new limit of 0x36, peaks at 0x36 and then wraps.
- R6: With the buffering mode on, a LIMIT write is held back until the next update event. For example, a counter at 0x31 with an active limit of 0xF5 still runs to 0xF5. After it wraps, it peaks at the new value 0x36.
- R7: A new divide value is used only after the next update event.
- R8: Writing 1 to bit 0 of FORCE sets a command bit. On the following clock edge the counter and divide stage clear, the update event takes place (both buffered copies load, the flag sets), and the command bit reads 0 again.
- R9: Writing 0 to bit 0 of STATUS clears the flag, and writing 1 there changes nothing. If an update event lands on the same edge as a clearing write, the flag ends up set.
- R10: `irq` is high exactly when the flag is 1 and CTRL bit 2 (interrupt enable) is 1.
- R11: The register map uses these addresses:
  - CTRL = 0: bit 0 is RUN, bit 1 is the buffering mode, bit 2 is the interrupt enable.
  - FORCE = 1: bit 0 is the command bit.
  - STATUS = 2: bit 0 is the flag.
  - LIMIT = 3: reads return the written value.
  - DIVIDE = 4: reads return the written value.
  - COUNT = 5: the counter, readable and writable.
  - Unused bits and addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The counter is run with divide values 0, 2 and 3. This separates a per-clock step from a divided step, and it shows whether a new divide value is applied early. A new limit is written below the old one while the counter is mid-way up, once with buffering off and once with it on. The peak value reached before the wrap then tells the immediate path apart from the delayed path. The forced update is placed on the same edge as a flag-clearing write, which exposes the priority between set and clear. A behavioural model, compared every cycle, follows all of these sequences.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FORCE = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_LIMIT = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIV   = 3'd4;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd5;
  localparam int B_RUN = 0;
  localparam int B_BUF = 1;
  localparam int B_IE  = 2;

  typedef struct packed {
    logic ctrl;
    logic force_cmd;
    logic stat;
    logic limit;
    logic div;
    logic count;
  } wr_strobes_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              upd,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  limit_i,
  input  logic [PSC_W-1:0]  div_i,
  output wr_strobes_t       stb,
  output logic              run,
  output logic              buf_en,
  output logic              ie,
  output logic              cmd,
  output logic              flag,
  output logic [DATA_W-1:0] rdata
);
  logic run_q, buf_q, ie_q, cmd_q, flag_q;
  logic run_d, buf_d, ie_d, cmd_d, flag_d;

  always_comb begin
    stb.ctrl      = wr && (addr == A_CTRL);
    stb.force_cmd = wr && (addr == A_FORCE);
    stb.stat      = wr && (addr == A_STAT);
    stb.limit     = wr && (addr == A_LIMIT);
    stb.div       = wr && (addr == A_DIV);
    stb.count     = wr && (addr == A_COUNT);
  end

  always_comb begin
    run_d  = run_q;
    buf_d  = buf_q;
    ie_d   = ie_q;
    if (stb.ctrl) begin
      run_d = wdata[B_RUN];
      buf_d = wdata[B_BUF];
      ie_d  = wdata[B_IE];
    end
    cmd_d  = stb.force_cmd && wdata[0];
    flag_d = flag_q;
    if (upd)
      flag_d = 1'b1;
    else if (stb.stat && !wdata[0])
      flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      buf_q  <= 1'b0;
      ie_q   <= 1'b0;
      cmd_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      buf_q  <= buf_d;
      ie_q   <= ie_d;
      cmd_q  <= cmd_d;
      flag_q <= flag_d;
    end
  end

  assign run    = run_q;
  assign buf_en = buf_q;
  assign ie     = ie_q;
  assign cmd    = cmd_q;
  assign flag   = flag_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  begin
        rdata[B_RUN] = run_q;
        rdata[B_BUF] = buf_q;
        rdata[B_IE]  = ie_q;
      end
      A_FORCE: rdata[0] = cmd_q;
      A_STAT:  rdata[0] = flag_q;
      A_LIMIT: rdata = DATA_W'(limit_i);
      A_DIV:   rdata = DATA_W'(div_i);
      A_COUNT: rdata = DATA_W'(cnt_i);
      default: rdata = '0;
    endcase
  end

  // R8: the command bit lasts one cycle unless rewritten
  p_cmd_selfclear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q && !(stb.force_cmd && wdata[0])) |=> !cmd_q);
  // R9: an update event always leaves the flag set
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> flag_q);
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cmd,
  input  logic             upd,
  input  logic             div_wr,
  input  logic [PSC_W-1:0] div_data,
  output logic             tick,
  output logic [PSC_W-1:0] div_pre
);
  logic [PSC_W-1:0] pre_q, act_q, pc_q;
  logic [PSC_W-1:0] pre_d, act_d, pc_d;

  always_comb begin
    tick  = run && (pc_q == act_q);
    pre_d = div_wr ? div_data : pre_q;
    act_d = upd ? pre_q : act_q;
    if (cmd)
      pc_d = '0;
    else if (tick)
      pc_d = '0;
    else if (run)
      pc_d = pc_q + 1'b1;
    else
      pc_d = pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
      pc_q  <= '0;
    end else begin
      pre_q <= pre_d;
      act_q <= act_d;
      pc_q  <= pc_d;
    end
  end

  assign div_pre = pre_q;

  // R7: the active divide value moves only on an update event
  p_div_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(act_q));
  // R3: divide stage frozen while stopped
  p_div_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cmd) |=> $stable(pc_q));
endmodule

// File: rtl/timer_core.sv
module timer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             cmd,
  input  logic             upd,
  input  logic             buf_en,
  input  logic             lim_wr,
  input  logic [CNT_W-1:0] lim_data,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_data,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] lim_pre,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, pre_q, act_q;
  logic [CNT_W-1:0] cnt_d, pre_d, act_d;

  always_comb begin
    wrap  = tick && (cnt_q == act_q);
    pre_d = lim_wr ? lim_data : pre_q;
    if (lim_wr && !buf_en)
      act_d = lim_data;
    else if (upd)
      act_d = pre_q;
    else
      act_d = act_q;
    if (cmd)
      cnt_d = '0;
    else if (cnt_wr)
      cnt_d = cnt_data;
    else if (wrap)
      cnt_d = '0;
    else if (tick)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      pre_q <= pre_d;
      act_q <= act_d;
    end
  end

  assign cnt     = cnt_q;
  assign lim_pre = pre_q;

  // R4: a wrap returns the counter to zero
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !cnt_wr && !cmd) |=> (cnt_q == '0));
  // R3: counter frozen while stopped
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr && !cmd) |=> $stable(cnt_q));
  // R6: buffered limit waits for an update event
  p_limit_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && !upd) |=> $stable(act_q));
endmodule

// File: rtl/basic_timer.sv
module basic_timer
  import timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  wr_strobes_t      stb;
  logic             run, buf_en, ie, cmd, flag, tick, wrap, upd;
  logic [CNT_W-1:0] cnt, lim_pre;
  logic [PSC_W-1:0] div_pre;

  assign upd = wrap || cmd;

  timer_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .upd(upd), .cnt_i(cnt), .limit_i(lim_pre), .div_i(div_pre), .stb(stb),
    .run(run), .buf_en(buf_en), .ie(ie), .cmd(cmd), .flag(flag),
    .rdata(reg_rdata)
  );

  timer_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .cmd(cmd), .upd(upd),
    .div_wr(stb.div), .div_data(reg_wdata[PSC_W-1:0]), .tick(tick),
    .div_pre(div_pre)
  );

  timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .cmd(cmd), .upd(upd),
    .buf_en(buf_en), .lim_wr(stb.limit), .lim_data(reg_wdata[CNT_W-1:0]),
    .cnt_wr(stb.count), .cnt_data(reg_wdata[CNT_W-1:0]), .cnt(cnt),
    .lim_pre(lim_pre), .wrap(wrap)
  );

  assign irq = flag && ie;

  // R10: a clear flag never raises the interrupt
  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> !irq);
endmodule

// File: tb/basic_timer_test.sv
module basic_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd5;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  basic_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic        m_run, m_buf, m_ie, m_cmd, m_flag;
  logic [15:0] m_lpre, m_lact, m_dpre, m_dact, m_pc, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_buf = 0; m_ie = 0; m_cmd = 0; m_flag = 0;
      m_lpre = 0; m_lact = 0; m_dpre = 0; m_dact = 0; m_pc = 0; m_cnt = 0;
    end else begin
      bit step, wr_now, upd;
      logic [15:0] old_lpre, old_dpre;
      step   = m_run && (m_pc == m_dact);
      wr_now = m_run && step && (m_cnt == m_lact);
      upd    = wr_now || m_cmd;
      old_lpre = m_lpre;
      old_dpre = m_dpre;
      if (m_cmd) m_cnt = 0;
      else if (reg_wr && reg_addr == 5) m_cnt = reg_wdata;
      else if (wr_now) m_cnt = 0;
      else if (step) m_cnt = m_cnt + 16'd1;
      if (m_cmd || step) m_pc = 0;
      else if (m_run) m_pc = m_pc + 16'd1;
      if (reg_wr && reg_addr == 3 && !m_buf) m_lact = reg_wdata;
      else if (upd) m_lact = old_lpre;
      if (upd) m_dact = old_dpre;
      if (reg_wr && reg_addr == 3) m_lpre = reg_wdata;
      if (reg_wr && reg_addr == 4) m_dpre = reg_wdata;
      if (upd) m_flag = 1;
      else if (reg_wr && reg_addr == 2 && !reg_wdata[0]) m_flag = 0;
      m_cmd = reg_wr && reg_addr == 1 && reg_wdata[0];
      if (reg_wr && reg_addr == 0) begin
        m_run = reg_wdata[0]; m_buf = reg_wdata[1]; m_ie = reg_wdata[2];
      end
    end
  end

  function automatic logic [15:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {13'd0, m_ie, m_buf, m_run};
      3'd1: return {15'd0, m_cmd};
      3'd2: return {15'd0, m_flag};
      3'd3: return m_lpre;
      3'd4: return m_dpre;
      3'd5: return m_cnt;
      default: return 16'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R11";
      3'd1: return "R8";
      3'd2: return "R9";
      3'd3: return "R5";
      3'd4: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tag_of(reg_addr), reg_rdata, model_read(reg_addr));
      check("R10", {15'd0, irq}, {15'd0, m_flag & m_ie});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0; reg_addr = 3'd5;
  endtask

  task automatic wr_pair(input logic [2:0] a1, input logic [15:0] d1,
                         input logic [2:0] a2, input logic [15:0] d2);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a1; reg_wdata = d1;
    @(posedge clk); #1;
    reg_addr = a2; reg_wdata = d2;
    @(posedge clk); #1;
    reg_wr = 0; reg_addr = 3'd5;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] v);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic peak_before_wrap(output logic [15:0] maxv);
    bit seen = 0;
    maxv = 0;
    @(posedge clk); #1; reg_addr = 3'd5;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (reg_rdata != 0) seen = 1;
      if (seen && reg_rdata == 0) break;
      if (reg_rdata > maxv) maxv = reg_rdata;
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [15:0] v, a, b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int k = 0; k < 6; k++) begin
      peek(3'(k), v);
      check("R1", v, 16'd0);
    end
    check("R1", {15'd0, irq}, 16'd0);
    // R11 map readback
    wr(3'd0, 16'h0006);
    peek(3'd0, v); check("R11", v, 16'h0006);
    wr(3'd0, 16'h0000);
    // R2 per-clock stepping
    wr(3'd3, 16'hFFFF);
    wr(3'd0, 16'h0001);
    peek(3'd5, a); repeat (5) @(negedge clk); b = reg_rdata;
    check("R2", b - a, 16'd5);
    // R2 divide by 3
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'd2);
    wr(3'd1, 16'h0001);
    wr(3'd0, 16'h0001);
    peek(3'd5, a); repeat (6) @(negedge clk); b = reg_rdata;
    check("R2", b - a, 16'd2);
    // R3 hold while stopped
    wr(3'd0, 16'h0000);
    peek(3'd5, a); repeat (10) @(negedge clk); b = reg_rdata;
    check("R3", b, a);
    wr(3'd4, 16'd0);
    wr(3'd1, 16'h0001);
    // R5 immediate limit
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h00FF);
    wr(3'd5, 16'h0031);
    wr(3'd0, 16'h0001);
    wr(3'd3, 16'h0036);
    peak_before_wrap(v);
    check("R5", v, 16'h0036);
    peek(3'd2, v); check("R4", v, 16'd1);
    // R6 buffered limit
    wr(3'd0, 16'h0002);
    wr(3'd3, 16'h00F5);
    wr(3'd1, 16'h0001);
    wr(3'd5, 16'h0031);
    wr(3'd0, 16'h0003);
    wr(3'd3, 16'h0036);
    peak_before_wrap(v);
    check("R6", v, 16'h00F5);
    peak_before_wrap(v);
    check("R6", v, 16'h0036);
    // R7 divide value waits for update
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h7FFF);
    wr(3'd5, 16'h0000);
    wr(3'd4, 16'd3);
    wr(3'd0, 16'h0001);
    peek(3'd5, a); repeat (8) @(negedge clk); b = reg_rdata;
    check("R7", b - a, 16'd8);
    wr(3'd1, 16'h0001);
    repeat (3) @(posedge clk);
    peek(3'd5, a); repeat (8) @(negedge clk); b = reg_rdata;
    check("R7", b - a, 16'd2);
    // R8 forced update
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0000);
    wr(3'd5, 16'h0055);
    wr(3'd1, 16'h0001);
    repeat (2) @(posedge clk);
    peek(3'd5, v); check("R8", v, 16'd0);
    peek(3'd1, v); check("R8", v, 16'd0);
    peek(3'd2, v); check("R8", v, 16'd1);
    // R9 clear, write-one ignored, set wins
    wr(3'd2, 16'h0000);
    peek(3'd2, v); check("R9", v, 16'd0);
    wr(3'd2, 16'h0001);
    peek(3'd2, v); check("R9", v, 16'd0);
    wr_pair(3'd1, 16'h0001, 3'd2, 16'h0000);
    peek(3'd2, v); check("R9", v, 16'd1);
    // R10 interrupt gating
    wr(3'd0, 16'h0004);
    @(negedge clk); check("R10", {15'd0, irq}, 16'd1);
    wr(3'd2, 16'h0000);
    @(negedge clk); check("R10", {15'd0, irq}, 16'd0);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0001);
    repeat (2) @(posedge clk);
    @(negedge clk); check("R10", {15'd0, irq}, 16'd0);
    repeat (4) @(posedge clk);
    finish_up();
  end
endmodule